// File: doc/BRIEF.md
# Header Request Queue with Destination Decode

This block sits between the stream of packet headers arriving from line cards and a header-processing engine. Each queued entry is a sequence of 64-bit words. The first word is a generic 8-byte link-layer header, and the words after it carry the first 24 or 56 bytes of the packet, so an entry is 4 or 8 words long. The first word also carries a packet identifier that names the packet and the interface holding its body. The engine pops words from the front of the queue. When the first word of an entry is delivered, the block copies that word's identifier into a holding register. The identifier therefore never has to pass through the engine's software.

The engine returns the updated header by writing words into an address window. The write address selects the destination: the upper nibble picks one of fifteen outbound cards and the lower nibble picks one of sixteen interfaces on that card. One card code means discard. For each write, the block joins the held identifier with the written word and emits a registered dispatch record. The final write of a header releases the held identifier. The holding register can also be loaded directly, so that headers can be handled out of queue order.

Top module: `hdr_req_dispatch`

## Requirements
- R1: After synchronous reset, `in_ready` is 1, and `rd_valid`, `hold_valid`, `out_valid` and `err` are all 0.
- R2: Accepted words leave in push order. A pop request (`rd_en`) made while the queue holds data returns `rd_data` and `rd_first`, with `rd_valid` high for one cycle, in the cycle after the request.
- R3: When `DEPTH` words are queued, `in_ready` is 0 and a push is ignored. No accepted word is lost or duplicated.
- R4: A pop request made while the queue is empty is ignored, and `rd_valid` stays 0.
- R5: In the cycle after a word with `rd_first`=1 is delivered, `hold_id` equals the identifier that was pushed with that word (`in_id` sampled when `in_first`=1) and `hold_valid` is 1. Delivering a word with `rd_first`=0 leaves the holding register unchanged.
- R6: A write (`wr_en`) made while an identifier is held produces, one cycle later, a record with `out_valid`=1, `out_id` equal to the held identifier, and `out_last`=`wr_last`. The write address is decoded as card = `wr_addr[7:4]` and interface = `wr_addr[3:0]`. For cards 0 to 14, the record has `out_drop`=0, `out_card`/`out_intf` equal to the decoded fields, and `out_data`=`wr_data`.
- R7: A write with card value 15 produces a discard record: `out_drop`=1, with `out_data`, `out_card` and `out_intf` all 0, and the held identifier in `out_id`.
- R8: A write with `wr_last`=1 while an identifier is held clears `hold_valid` in the following cycle.
- R9: A write made while no identifier is held raises `err` for one cycle in the following cycle and emits no record.
- R10: `id_wr_en` loads `id_wr_val` into the holding register and sets `hold_valid`. This load takes priority over both a queue load and a release in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Push request |
| in_ready | output | 1 | Queue can accept a word |
| in_first | input | 1 | Word is the first of an entry |
| in_id | input | ID_W | Packet identifier, used on the first word |
| in_data | input | WORD_W | Header word |
| rd_en | input | 1 | Pop request from the engine |
| rd_valid | output | 1 | Popped word present |
| rd_first | output | 1 | Popped word is the first of an entry |
| rd_data | output | WORD_W | Popped word |
| hold_valid | output | 1 | Holding register has an identifier |
| hold_id | output | ID_W | Held identifier |
| id_wr_en | input | 1 | Direct load of the holding register |
| id_wr_val | input | ID_W | Value for the direct load |
| wr_en | input | 1 | Updated-header write |
| wr_addr | input | 8 | Destination: card in [7:4], interface in [3:0] |
| wr_data | input | WORD_W | Updated header word |
| wr_last | input | 1 | Final word of the updated header |
| out_valid | output | 1 | Dispatch record present |
| out_drop | output | 1 | Record is a discard |
| out_card | output | 4 | Destination card |
| out_intf | output | 4 | Destination interface |
| out_id | output | ID_W | Packet identifier of the record |
| out_data | output | WORD_W | Header word of the record |
| out_last | output | 1 | Final record of the header |
| err | output | 1 | Write arrived with no identifier held |

## Verification
The assertions assume that `rst` is held high from time zero until the first edges, and that `in_id` is meaningful only on words pushed with `in_first` set. The release and hold-load properties exclude cycles in which a direct identifier load is also requested, because the direct load legitimately overrides them. The stimulus drives each input one at a time at the falling edge. It pushes only while `in_ready` is high, apart from one deliberate overfill, and it spaces pops two cycles apart so that each identifier load can be observed before the next word arrives. Same-cycle collisions between a direct load and a release are driven only in a dedicated directed case.

// File: rtl/hq_pkg.sv
package hq_pkg;
  localparam int unsigned CARD_W = 4;
  localparam int unsigned INTF_W = 4;
  localparam int unsigned ADDR_W = CARD_W + INTF_W;
  localparam logic [CARD_W-1:0] CARD_DISCARD = {CARD_W{1'b1}};

  typedef struct packed {
    logic              drop;
    logic [CARD_W-1:0] card;
    logic [INTF_W-1:0] intf;
  } dest_t;

  function automatic dest_t hq_decode(input logic [ADDR_W-1:0] a);
    dest_t d;
    d.card = a[ADDR_W-1:INTF_W];
    d.intf = a[INTF_W-1:0];
    d.drop = (d.card == CARD_DISCARD);
    return d;
  endfunction
endpackage

// File: rtl/hq_fifo.sv
module hq_fifo #(
  parameter int unsigned W     = 81,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         pop_vld
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          empty, push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
    if (pop_ok)  pop_data  <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      pop_vld <= 1'b0;
    end else begin
      pop_vld <= pop_ok;
      if (push_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> full); // R3
  AST_EMPTY_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (empty && !push) |=> (!pop_vld && empty)); // R4
endmodule

// File: rtl/hq_idhold.sv
module hq_idhold #(
  parameter int unsigned ID_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            direct_en,
  input  logic [ID_W-1:0] direct_val,
  input  logic            load_en,
  input  logic [ID_W-1:0] load_val,
  input  logic            release_en,
  output logic            valid,
  output logic [ID_W-1:0] id
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      id    <= '0;
    end else if (direct_en) begin
      valid <= 1'b1;
      id    <= direct_val;
    end else if (load_en) begin
      valid <= 1'b1;
      id    <= load_val;
    end else if (release_en) begin
      valid <= 1'b0;
    end
  end

  AST_DIRECT_WINS: assert property (@(posedge clk) disable iff (rst)
    direct_en |=> (valid && id == $past(direct_val))); // R10
endmodule

// File: rtl/hq_dispatch.sv
module hq_dispatch
  import hq_pkg::*;
#(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned ID_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_last,
  input  logic              held,
  input  logic [ID_W-1:0]   held_id,
  output logic              release_id,
  output logic              out_valid,
  output logic              out_drop,
  output logic [CARD_W-1:0] out_card,
  output logic [INTF_W-1:0] out_intf,
  output logic [ID_W-1:0]   out_id,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              err
);
  dest_t dst;
  logic  accept;

  assign dst        = hq_decode(wr_addr);
  assign accept     = wr_en && held;
  assign release_id = accept && wr_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_drop  <= 1'b0;
      out_card  <= '0;
      out_intf  <= '0;
      out_id    <= '0;
      out_data  <= '0;
      out_last  <= 1'b0;
      err       <= 1'b0;
    end else begin
      out_valid <= accept;
      err       <= wr_en && !held;
      if (accept) begin
        out_drop <= dst.drop;
        out_card <= dst.drop ? '0 : dst.card;
        out_intf <= dst.drop ? '0 : dst.intf;
        out_data <= dst.drop ? '0 : wr_data;
        out_id   <= held_id;
        out_last <= wr_last;
      end
    end
  end
endmodule

// File: rtl/hdr_req_dispatch.sv
module hdr_req_dispatch
  import hq_pkg::*;
#(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned ID_W   = 16,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_first,
  input  logic [ID_W-1:0]   in_id,
  input  logic [WORD_W-1:0] in_data,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic              rd_first,
  output logic [WORD_W-1:0] rd_data,
  output logic              hold_valid,
  output logic [ID_W-1:0]   hold_id,
  input  logic              id_wr_en,
  input  logic [ID_W-1:0]   id_wr_val,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_last,
  output logic              out_valid,
  output logic              out_drop,
  output logic [CARD_W-1:0] out_card,
  output logic [INTF_W-1:0] out_intf,
  output logic [ID_W-1:0]   out_id,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              err
);
  localparam int unsigned FW = 1 + ID_W + WORD_W;

  logic          full, release_id;
  logic [FW-1:0] q_word;
  logic [ID_W-1:0] q_id;

  hq_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(in_valid), .push_data({in_first, in_id, in_data}), .full(full),
    .pop(rd_en), .pop_data(q_word), .pop_vld(rd_valid)
  );

  assign in_ready = !full;
  assign rd_first = q_word[FW-1];
  assign q_id     = q_word[WORD_W +: ID_W];
  assign rd_data  = q_word[WORD_W-1:0];

  hq_idhold #(.ID_W(ID_W)) u_hold (
    .clk(clk), .rst(rst),
    .direct_en(id_wr_en), .direct_val(id_wr_val),
    .load_en(rd_valid && rd_first), .load_val(q_id),
    .release_en(release_id),
    .valid(hold_valid), .id(hold_id)
  );

  hq_dispatch #(.WORD_W(WORD_W), .ID_W(ID_W)) u_disp (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_last(wr_last),
    .held(hold_valid), .held_id(hold_id), .release_id(release_id),
    .out_valid(out_valid), .out_drop(out_drop), .out_card(out_card),
    .out_intf(out_intf), .out_id(out_id), .out_data(out_data),
    .out_last(out_last), .err(err)
  );

  AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_first && !id_wr_en) |=> (hold_valid && hold_id == $past(q_id))); // R5
  AST_ROUTE_ID: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hold_valid) |=> (out_valid && out_id == $past(hold_id) && !err)); // R6
  AST_DROP_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_drop) |-> (out_data == '0 && out_card == '0 && out_intf == '0)); // R7
  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_last && hold_valid && !id_wr_en && !(rd_valid && rd_first)) |=> !hold_valid); // R8
  AST_NO_ID_ERR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hold_valid) |=> (err && !out_valid)); // R9
endmodule

// File: tb/test_hdr_req_dispatch.sv
`timescale 1ns/1ps
module test_hdr_req_dispatch;
  localparam int WW = 64, IW = 16, DEPTH = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_first = 0, rd_en = 0, id_wr_en = 0, wr_en = 0, wr_last = 0;
  logic [IW-1:0] in_id = '0, id_wr_val = '0;
  logic [WW-1:0] in_data = '0, wr_data = '0;
  logic [7:0] wr_addr = '0;
  logic in_ready, rd_valid, rd_first, hold_valid, out_valid, out_drop, out_last, err;
  logic [WW-1:0] rd_data, out_data;
  logic [IW-1:0] hold_id, out_id;
  logic [3:0] out_card, out_intf;

  hdr_req_dispatch #(.WORD_W(WW), .ID_W(IW), .DEPTH(DEPTH)) i_hdr_req_dispatch (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [WW-1:0] mq_data[$];
  logic          mq_first[$];
  logic [IW-1:0] mq_id[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_word(input logic first, input logic [IW-1:0] id, input logic [WW-1:0] d);
    bit acc;
    acc = in_ready;
    in_valid = 1; in_first = first; in_id = id; in_data = d;
    @(negedge clk);
    in_valid = 0;
    if (acc) begin mq_data.push_back(d); mq_first.push_back(first); mq_id.push_back(id); end
  endtask

  // pop one word, check it (R2), then check the holding register a cycle later (R5)
  task automatic pop_check(output logic [WW-1:0] got);
    logic [WW-1:0] ed; logic ef; logic [IW-1:0] ei; logic pv; logic [IW-1:0] pid;
    ed = mq_data.pop_front(); ef = mq_first.pop_front(); ei = mq_id.pop_front();
    pv = hold_valid; pid = hold_id;
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    got = rd_data;
    chk(rd_valid == 1 && rd_data == ed && rd_first == ef, "R2 pop order", rd_data, ed);
    @(negedge clk);
    if (ef) chk(hold_valid && hold_id == ei, "R5 id held on first word", hold_id, ei);
    else    chk(hold_valid == pv && hold_id == pid, "R5 non-first word leaves hold", hold_id, pid);
  endtask

  function automatic logic [WW-1:0] exp_data(input logic [7:0] a, input logic [WW-1:0] d);
    return (a[7:4] == 4'hF) ? '0 : d;
  endfunction

  task automatic write_check(input logic [7:0] a, input logic [WW-1:0] d, input logic last,
                             input logic [IW-1:0] eid);
    wr_en = 1; wr_addr = a; wr_data = d; wr_last = last;
    @(negedge clk);
    wr_en = 0; wr_last = 0;
    chk(out_valid && !err && out_id == eid && out_last == last, "R6 record id", out_id, eid);
    if (a[7:4] == 4'hF)
      chk(out_drop && out_data == 0 && out_card == 0 && out_intf == 0, "R7 discard record", out_data, 0);
    else
      chk(!out_drop && out_card == a[7:4] && out_intf == a[3:0] && out_data == exp_data(a, d),
          "R6 route decode", {out_card, out_intf, out_data[31:0]}, {a, d[31:0]});
  endtask

  task automatic push_entry(input int len, input logic [IW-1:0] id);
    for (int i = 0; i < len; i++) push_word(i == 0, id, {$urandom, $urandom});
  endtask

  task automatic process_entry(input int len, input logic [IW-1:0] id, input logic [7:0] a);
    logic [WW-1:0] w;
    for (int i = 0; i < len; i++) begin
      pop_check(w);
      write_check(a, ~w, i == len - 1, id);
    end
    chk(!hold_valid, "R8 release after last write", hold_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] a;
    logic [IW-1:0] ida, idb;
    int len;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(in_ready && !rd_valid && !hold_valid && !out_valid && !err, "R1 reset state",
        {in_ready, rd_valid, hold_valid, out_valid, err}, 5'b10000);
    // R4 pop on empty
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk(!rd_valid, "R4 pop while empty", rd_valid, 0);
    // R9 write with nothing held
    wr_en = 1; wr_addr = 8'h21; wr_data = 64'h55; @(negedge clk); wr_en = 0;
    chk(err && !out_valid, "R9 write without id", {err, out_valid}, 2'b10);
    @(negedge clk);
    chk(!err, "R9 error is one pulse", err, 0);
    // R3 fill the queue with two 8-word entries, then overfill
    ida = 16'hA11A; idb = 16'hB22B;
    push_entry(8, ida);
    push_entry(8, idb);
    chk(!in_ready, "R3 ready low when full", in_ready, 0);
    push_word(1, 16'hDEAD, 64'hBAD);
    chk(mq_data.size() == DEPTH, "R3 overfill ignored", mq_data.size(), DEPTH);
    process_entry(8, ida, 8'h3C);
    chk(in_ready, "R3 ready returns", in_ready, 1);
    process_entry(8, idb, 8'hF7);
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk(!rd_valid, "R4 pop after drain", rd_valid, 0);
    // R10 direct load, then collision with a release
    id_wr_en = 1; id_wr_val = 16'h0C0C; @(negedge clk); id_wr_en = 0;
    chk(hold_valid && hold_id == 16'h0C0C, "R10 direct load", hold_id, 16'h0C0C);
    id_wr_en = 1; id_wr_val = 16'h0B0B;
    wr_en = 1; wr_addr = 8'hE5; wr_data = 64'h1234; wr_last = 1;
    @(negedge clk);
    id_wr_en = 0; wr_en = 0; wr_last = 0;
    chk(out_valid && out_id == 16'h0C0C, "R10 record uses old id", out_id, 16'h0C0C);
    chk(hold_valid && hold_id == 16'h0B0B, "R10 direct load beats release", hold_id, 16'h0B0B);
    write_check(8'h00, 64'hFACE, 1, 16'h0B0B);
    chk(!hold_valid, "R8 release", hold_valid, 0);
    // random entries
    for (int n = 0; n < 60; n++) begin
      len = ($urandom % 2) ? 8 : 4;
      ida = IW'($urandom);
      a = {(($urandom % 4) == 0) ? 4'hF : 4'($urandom % 15), 4'($urandom)};
      push_entry(len, ida);
      process_entry(len, ida, a);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule